// File: doc/BRIEF.md
# Collision-Free Line Grouping Engine

This engine sets up the redundancy for a two-bank cache that runs at a supply voltage where some SRAM cells fail. Each cache line is split into equal chunks. For every line the engine is given a bitmap with one bit per chunk, and a set bit means the chunk holds at least one bad cell. From these bitmaps the engine builds repair groups. Each group has one spare line, called the sacrificial line, taken from one bank. It also has one or more data lines from the other bank. No two lines of a group may have a faulty chunk at the same chunk position. When a data line is read, its faulty chunks are replaced with the chunks at the same positions in the sacrificial line.

The engine starts on a one-cycle start pulse. It emits one memory-map write for every line of both banks. Each write either places the line in a group, with its slot number, or marks the line disabled. It emits one fault-map write for each formed group, up to the depth of the fault map. When the run is complete it raises a done flag and holds the group and disabled-line counts. An overflow flag reports that more groups were formed than the fault map can hold.

The controller is a six-state machine:
- **IDLE**: after reset. Goes to SCREEN on start.
- **SCREEN**: visits every line once. Moves to PICK after the last line of bank 1.
- **PICK**: goes to FILL when any line is still free, and to DONE when none is.
- **FILL**: scans the other bank one line per cycle. Moves to CLOSE after the last line.
- **CLOSE**: always returns to PICK.
- **DONE**: holds the results. Goes to SCREEN on start.

Top module: `lg_group_engine`

## Requirements
- R1: After reset, done, busy, overflow, both counts and both write strobes are 0.
- R2: Chunk c of line l in bank b is bit (b*LINES+l)*CHUNKS+c of `fault_i`. In SCREEN, a line with at least DIS_THR faulty chunks (default CHUNKS/2+1) gets a disabled memory-map entry and is never grouped.
- R3: The sacrificial line of each group is the lowest free line of the bank that has more lines assigned to groups. A tie goes to bank 0, so the first group starts at the lowest eligible line of bank 0. If only one bank still has free lines, that bank is used.
- R4: Data lines come from the other bank and are tested in ascending line order. A free line joins the group only if none of its faulty chunks overlaps the combined faulty chunks of the sacrificial line and the members already taken. Otherwise it is skipped.
- R5: Groups are numbered from 0 in the order they are formed. The sacrificial line has slot 0. Members get slots 1, 2, 3 and so on, in the order they are taken.
- R6: The fault-map word of a group holds one AW-bit field per chunk, with chunk c at bits c*AW up. The field holds the slot of the member that is faulty at that chunk, or 0 if no member is. A member with no faulty chunks changes no field.
- R7: A sacrificial line that gets no member is written as disabled, and no group is counted for it.
- R8: A run writes exactly one memory-map entry per line. It ends in DONE once no line is free. `grp_count` and `dis_count` give the totals.
- R9: A group whose number is FM_DEPTH or higher gets no fault-map write and sets `overflow`.
- R10: A start pulse while busy has no effect on the run in progress.
- R11: In DONE, done stays high and the counts and overflow stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted in IDLE or DONE) |
| fault_i | input | 2*LINES*CHUNKS | Faulty-chunk bitmap for all lines, held during a run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete, results valid |
| overflow | output | 1 | More groups than fault-map depth |
| grp_count | output | CW | Groups formed |
| dis_count | output | CW | Lines disabled |
| mm_we | output | 1 | Memory-map write strobe |
| mm_bank | output | 1 | Bank of the written line |
| mm_line | output | LW | Line index within the bank |
| mm_grp | output | GW | Group number |
| mm_slot | output | AW | Slot in group (0 = sacrificial) |
| mm_dis | output | 1 | Line disabled |
| fm_we | output | 1 | Fault-map write strobe |
| fm_grp | output | GW | Fault-map row |
| fm_data | output | CHUNKS*AW | Per-chunk member slot fields |

## Verification
The assertions assume that `fault_i` stays constant from start to done. They also assume that `start` is only acted on outside a run; the combined fault pattern is only required to grow within a FILL scan under that first assumption. The bench changes the bitmap only while the engine is idle or done. It mixes random bitmaps of several fault densities with directed bitmaps: no faults, every line heavy, every line colliding with every other, and one-to-one pairings that overrun the fault map. One run pulses start a second time in the middle of the scan.

// File: rtl/lg_pkg.sv
package lg_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCREEN,
        S_PICK,
        S_FILL,
        S_CLOSE,
        S_DONE
    } lg_state_e;

endpackage

// File: rtl/lg_first_free.sv
module lg_first_free #(
    parameter int LINES = 8,
    localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
)(
    input  logic [LINES-1:0] used_i,
    output logic             any_o,
    output logic [LW-1:0]    idx_o
);

    always_comb begin
        any_o = ~&used_i;
        idx_o = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!used_i[i]) begin
                idx_o = LW'(i);
            end
        end
    end

endmodule

// File: rtl/lg_line_eval.sv
module lg_line_eval #(
    parameter int CHUNKS  = 4,
    parameter int AW      = 4,
    parameter int DIS_THR = 3
)(
    input  logic [CHUNKS-1:0]    pat_i,
    input  logic [CHUNKS-1:0]    acc_i,
    input  logic [CHUNKS*AW-1:0] fm_i,
    input  logic [AW-1:0]        slot_i,
    output logic                 heavy_o,
    output logic                 clash_o,
    output logic [CHUNKS*AW-1:0] fm_o
);

    assign heavy_o = ($countones(pat_i) >= DIS_THR);
    assign clash_o = |(pat_i & acc_i);

    for (genvar c = 0; c < CHUNKS; c++) begin : g_field
        assign fm_o[c*AW +: AW] = pat_i[c] ? slot_i : fm_i[c*AW +: AW];
    end

endmodule

// File: rtl/lg_group_engine.sv
module lg_group_engine
    import lg_pkg::*;
#(
    parameter int LINES    = 8,
    parameter int CHUNKS   = 4,
    parameter int DIS_THR  = CHUNKS / 2 + 1,
    parameter int FM_DEPTH = 4,
    localparam int LW = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int AW = $clog2(LINES + 1),
    localparam int GW = $clog2(LINES + 1),
    localparam int CW = $clog2(2 * LINES + 1)
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [2*LINES*CHUNKS-1:0]  fault_i,
    output logic                       busy,
    output logic                       done,
    output logic                       overflow,
    output logic [CW-1:0]              grp_count,
    output logic [CW-1:0]              dis_count,
    output logic                       mm_we,
    output logic                       mm_bank,
    output logic [LW-1:0]              mm_line,
    output logic [GW-1:0]              mm_grp,
    output logic [AW-1:0]              mm_slot,
    output logic                       mm_dis,
    output logic                       fm_we,
    output logic [GW-1:0]              fm_grp,
    output logic [CHUNKS*AW-1:0]       fm_data
);

    lg_state_e state_q, state_d;

    logic [1:0][LINES-1:0] used_q;
    logic [1:0][CW-1:0]    asg_q;
    logic                  scr_bank_q;
    logic [LW-1:0]         scr_line_q;
    logic                  sac_bank_q;
    logic [LW-1:0]         sac_line_q;
    logic [LW-1:0]         scan_line_q;
    logic [CHUNKS-1:0]     acc_q;
    logic [CHUNKS*AW-1:0]  fmacc_q;
    logic [AW-1:0]         slot_q;

    logic [1:0]            any_free;
    logic [1:0][LW-1:0]    first_idx;
    logic                  pick_bank;
    logic [LW-1:0]         pick_line;
    logic                  other_bank;
    logic                  sel_bank;
    logic [LW-1:0]         sel_line;
    int unsigned           sel_base;
    logic [CHUNKS-1:0]     sel_pat;
    logic                  heavy, clash;
    logic [CHUNKS*AW-1:0]  fm_merged;
    logic                  fill_take;
    logic                  scr_last, scan_last;

    // Per-bank lowest free line finders
    for (genvar b = 0; b < 2; b++) begin : g_bank
        lg_first_free #(.LINES(LINES)) u_ff (
            .used_i (used_q[b]),
            .any_o  (any_free[b]),
            .idx_o  (first_idx[b])
        );
    end

    // Bank with more assigned lines wins, tie to bank 0 (R3)
    assign pick_bank  = any_free[1] && (!any_free[0] || (asg_q[1] > asg_q[0]));
    assign pick_line  = first_idx[pick_bank];
    assign other_bank = ~sac_bank_q;

    always_comb begin
        unique case (state_q)
            S_SCREEN: begin sel_bank = scr_bank_q; sel_line = scr_line_q;  end
            S_FILL:   begin sel_bank = other_bank; sel_line = scan_line_q; end
            default:  begin sel_bank = pick_bank;  sel_line = pick_line;   end
        endcase
        sel_base = (int'(sel_bank) * LINES + int'(sel_line)) * CHUNKS;
        sel_pat  = fault_i[sel_base +: CHUNKS];
    end

    lg_line_eval #(.CHUNKS(CHUNKS), .AW(AW), .DIS_THR(DIS_THR)) u_eval (
        .pat_i   (sel_pat),
        .acc_i   (acc_q),
        .fm_i    (fmacc_q),
        .slot_i  (slot_q),
        .heavy_o (heavy),
        .clash_o (clash),
        .fm_o    (fm_merged)
    );

    assign fill_take = !used_q[other_bank][scan_line_q] && !clash;
    assign scr_last  = scr_bank_q && (scr_line_q == LW'(LINES - 1));
    assign scan_last = (scan_line_q == LW'(LINES - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_SCREEN;
            S_SCREEN: if (scr_last) state_d = S_PICK;
            S_PICK:   state_d = (|any_free) ? S_FILL : S_DONE;
            S_FILL:   if (scan_last) state_d = S_CLOSE;
            S_CLOSE:  state_d = S_PICK;
            S_DONE:   if (start) state_d = S_SCREEN;
        endcase
    end

    // Outputs and datapath
    always_comb begin
        busy = (state_q != S_IDLE) && (state_q != S_DONE);
        done = (state_q == S_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q      <= '0;
            asg_q       <= '0;
            scr_bank_q  <= 1'b0;
            scr_line_q  <= '0;
            sac_bank_q  <= 1'b0;
            sac_line_q  <= '0;
            scan_line_q <= '0;
            acc_q       <= '0;
            fmacc_q     <= '0;
            slot_q      <= '0;
            grp_count   <= '0;
            dis_count   <= '0;
            overflow    <= 1'b0;
            mm_we       <= 1'b0;
            mm_bank     <= 1'b0;
            mm_line     <= '0;
            mm_grp      <= '0;
            mm_slot     <= '0;
            mm_dis      <= 1'b0;
            fm_we       <= 1'b0;
            fm_grp      <= '0;
            fm_data     <= '0;
        end else begin
            mm_we <= 1'b0;
            fm_we <= 1'b0;
            unique case (state_q)
                S_IDLE, S_DONE: begin
                    if (start) begin
                        used_q     <= '0;
                        asg_q      <= '0;
                        grp_count  <= '0;
                        dis_count  <= '0;
                        overflow   <= 1'b0;
                        scr_bank_q <= 1'b0;
                        scr_line_q <= '0;
                    end
                end
                S_SCREEN: begin
                    if (heavy) begin
                        used_q[scr_bank_q][scr_line_q] <= 1'b1;
                        dis_count <= dis_count + CW'(1);
                        mm_we   <= 1'b1;
                        mm_bank <= scr_bank_q;
                        mm_line <= scr_line_q;
                        mm_grp  <= '0;
                        mm_slot <= '0;
                        mm_dis  <= 1'b1;
                    end
                    if (scr_line_q == LW'(LINES - 1)) begin
                        scr_line_q <= '0;
                        scr_bank_q <= 1'b1;
                    end else begin
                        scr_line_q <= scr_line_q + LW'(1);
                    end
                end
                S_PICK: begin
                    if (|any_free) begin
                        used_q[pick_bank][pick_line] <= 1'b1;
                        sac_bank_q  <= pick_bank;
                        sac_line_q  <= pick_line;
                        acc_q       <= sel_pat;
                        fmacc_q     <= '0;
                        slot_q      <= AW'(1);
                        scan_line_q <= '0;
                    end
                end
                S_FILL: begin
                    if (fill_take) begin
                        used_q[other_bank][scan_line_q] <= 1'b1;
                        acc_q   <= acc_q | sel_pat;
                        fmacc_q <= fm_merged;
                        slot_q  <= slot_q + AW'(1);
                        asg_q[other_bank] <= asg_q[other_bank] + CW'(1);
                        mm_we   <= 1'b1;
                        mm_bank <= other_bank;
                        mm_line <= scan_line_q;
                        mm_grp  <= grp_count[GW-1:0];
                        mm_slot <= slot_q;
                        mm_dis  <= 1'b0;
                    end
                    scan_line_q <= scan_line_q + LW'(1);
                end
                S_CLOSE: begin
                    mm_we   <= 1'b1;
                    mm_bank <= sac_bank_q;
                    mm_line <= sac_line_q;
                    mm_slot <= '0;
                    if (slot_q > AW'(1)) begin
                        mm_grp  <= grp_count[GW-1:0];
                        mm_dis  <= 1'b0;
                        asg_q[sac_bank_q] <= asg_q[sac_bank_q] + CW'(1);
                        grp_count <= grp_count + CW'(1);
                        if (int'(grp_count) < FM_DEPTH) begin
                            fm_we   <= 1'b1;
                            fm_grp  <= grp_count[GW-1:0];
                            fm_data <= fmacc_q;
                        end else begin
                            overflow <= 1'b1;
                        end
                    end else begin
                        mm_grp    <= '0;
                        mm_dis    <= 1'b1;
                        dis_count <= dis_count + CW'(1);
                    end
                end
            endcase
        end
    end

    // R11: results frozen while done and no new start
    a_r11_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(grp_count) && $stable(dis_count) && $stable(overflow)));

    // R9: fault-map writes stay inside the map
    a_r9_fm_in_depth: assert property (@(posedge clk) disable iff (!rst_n)
        fm_we |-> (int'(fm_grp) < FM_DEPTH));

    // R9: overflow is not lost during a run
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && busy) |=> overflow);

    // R8: no map traffic outside a run
    a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mm_we && !fm_we));

    // R4: combined fault pattern only grows during a fill scan
    a_r4_acc_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && $past(state_q) == S_FILL) |-> ((acc_q & $past(acc_q)) == $past(acc_q)));

    // R10: a run in progress keeps going regardless of start
    a_r10_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != S_PICK) |=> busy);

endmodule

// File: tb/lg_group_engine_tb.sv
module lg_group_engine_tb;

    localparam int L   = 8;
    localparam int CH  = 4;
    localparam int THR = CH / 2 + 1;
    localparam int FMD = 4;
    localparam int LW  = $clog2(L);
    localparam int AW  = $clog2(L + 1);
    localparam int GW  = $clog2(L + 1);
    localparam int CW  = $clog2(2 * L + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2*L*CH-1:0] flt = '0;
    logic busy, done, overflow, mm_we, mm_bank, mm_dis, fm_we;
    logic [CW-1:0] grp_count, dis_count;
    logic [LW-1:0] mm_line;
    logic [GW-1:0] mm_grp, fm_grp;
    logic [AW-1:0] mm_slot;
    logic [CH*AW-1:0] fm_data;

    always #2 clk = ~clk;

    lg_group_engine #(.LINES(L), .CHUNKS(CH), .DIS_THR(THR), .FM_DEPTH(FMD)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fault_i(flt),
        .busy(busy), .done(done), .overflow(overflow),
        .grp_count(grp_count), .dis_count(dis_count),
        .mm_we(mm_we), .mm_bank(mm_bank), .mm_line(mm_line), .mm_grp(mm_grp),
        .mm_slot(mm_slot), .mm_dis(mm_dis),
        .fm_we(fm_we), .fm_grp(fm_grp), .fm_data(fm_data)
    );

    int n_tests = 0;
    int n_fail  = 0;

    int got_cnt[2][L], got_dis[2][L], got_grp[2][L], got_slot[2][L];
    int fm_cnt[16];
    logic [CH*AW-1:0] got_fm[16];

    int e_dis[2][L], e_heavy[2][L], e_grp[2][L], e_slot[2][L];
    logic [CH*AW-1:0] e_fm[16];
    int e_ng, e_nd;
    int e_ovf;

    always @(negedge clk) begin
        if (mm_we) begin
            got_cnt[mm_bank][mm_line]++;
            got_dis[mm_bank][mm_line]  = int'(mm_dis);
            got_grp[mm_bank][mm_line]  = int'(mm_grp);
            got_slot[mm_bank][mm_line] = int'(mm_slot);
        end
        if (fm_we) begin
            fm_cnt[fm_grp]++;
            got_fm[fm_grp] = fm_data;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [CH-1:0] pat(input int b, input int l);
        return flt[(b*L + l)*CH +: CH];
    endfunction

    // Reference grouping computed from the requirements
    task automatic model();
        bit used[2][L];
        int asg[2];
        int ng, nd, f0, f1, sb, sl, ob, slot;
        logic [CH-1:0] acc;
        logic [CH*AW-1:0] fv;
        ng = 0; nd = 0; asg[0] = 0; asg[1] = 0;
        for (int k = 0; k < 16; k++) e_fm[k] = '0;
        for (int b = 0; b < 2; b++) begin
            for (int l = 0; l < L; l++) begin
                used[b][l] = 0; e_dis[b][l] = 0; e_heavy[b][l] = 0;
                e_grp[b][l] = 0; e_slot[b][l] = 0;
                if ($countones(pat(b, l)) >= THR) begin   // R2
                    used[b][l] = 1; e_dis[b][l] = 1; e_heavy[b][l] = 1; nd++;
                end
            end
        end
        forever begin
            f0 = -1; f1 = -1;
            for (int l = L - 1; l >= 0; l--) begin
                if (!used[0][l]) f0 = l;
                if (!used[1][l]) f1 = l;
            end
            if (f0 < 0 && f1 < 0) break;
            if (f0 >= 0 && f1 >= 0) sb = (asg[1] > asg[0]) ? 1 : 0;   // R3
            else sb = (f1 >= 0) ? 1 : 0;
            sl = (sb == 1) ? f1 : f0;
            ob = 1 - sb;
            used[sb][sl] = 1;
            acc = pat(sb, sl);
            fv = '0;
            slot = 1;
            for (int l = 0; l < L; l++) begin                         // R4
                if (!used[ob][l] && ((pat(ob, l) & acc) == '0)) begin
                    used[ob][l] = 1;
                    acc = acc | pat(ob, l);
                    for (int c = 0; c < CH; c++)
                        if (pat(ob, l)[c]) fv[c*AW +: AW] = AW'(slot);   // R6
                    e_grp[ob][l] = ng; e_slot[ob][l] = slot;
                    slot++; asg[ob]++;
                end
            end
            if (slot > 1) begin
                e_grp[sb][sl] = ng; e_slot[sb][sl] = 0; asg[sb]++;
                if (ng < FMD) e_fm[ng] = fv;
                ng++;
            end else begin                                             // R7
                e_dis[sb][sl] = 1; nd++;
            end
        end
        e_ng = ng; e_nd = nd; e_ovf = (ng > FMD) ? 1 : 0;
    endtask

    task automatic run(input logic [2*L*CH-1:0] f, input bit poke);
        int cyc;
        int lim;
        flt = f;
        model();
        for (int b = 0; b < 2; b++)
            for (int l = 0; l < L; l++) begin
                got_cnt[b][l] = 0; got_dis[b][l] = -1; got_grp[b][l] = -1; got_slot[b][l] = -1;
            end
        for (int k = 0; k < 16; k++) begin fm_cnt[k] = 0; got_fm[k] = '0; end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            chk("R10 busy after stray start", busy, 1);
        end
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        if (!done) begin chk("R8 run reaches done", 0, 1); return; end
        chk("R8 group count", grp_count, e_ng);
        chk("R8 disabled count", dis_count, e_nd);
        chk("R9 overflow flag", overflow, e_ovf);
        for (int b = 0; b < 2; b++) begin
            for (int l = 0; l < L; l++) begin
                chk($sformatf("R8 entries b%0d l%0d", b, l), got_cnt[b][l], 1);
                chk($sformatf("%s disable b%0d l%0d", e_heavy[b][l] ? "R2" : "R7", b, l),
                    got_dis[b][l], e_dis[b][l]);
                if (!e_dis[b][l]) begin
                    chk($sformatf("%s group b%0d l%0d", (e_slot[b][l] == 0) ? "R3" : "R4", b, l),
                        got_grp[b][l], e_grp[b][l]);
                    chk($sformatf("R5 slot b%0d l%0d", b, l), got_slot[b][l], e_slot[b][l]);
                end
            end
        end
        lim = (e_ng < FMD) ? e_ng : FMD;
        for (int k = 0; k < 16; k++) begin
            if (k < lim) begin
                chk($sformatf("R6 fm writes g%0d", k), fm_cnt[k], 1);
                chk($sformatf("R6 fm data g%0d", k), got_fm[k], e_fm[k]);
            end else begin
                chk($sformatf("R9 no fm write g%0d", k), fm_cnt[k], 0);
            end
        end
        repeat (3) @(negedge clk);
        chk("R11 done held", done, 1);
        chk("R11 count held", grp_count, e_ng);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [2*L*CH-1:0] f;
        logic [CH-1:0] p;
        int dens;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", done, 0);
        chk("R1 busy", busy, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 groups", grp_count, 0);
        chk("R1 disabled", dis_count, 0);
        chk("R1 strobes", {mm_we, fm_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle quiet", {busy, done}, 0);

        // R3/R7: no faults, one big group then lonely bank-0 lines
        run('0, 1'b0);
        // R2: every line heavy
        f = '0;
        for (int i = 0; i < 2*L; i++) f[i*CH +: CH] = CH'(4'b0111);
        run(f, 1'b0);
        // R7: every line collides with every other
        f = '0;
        for (int i = 0; i < 2*L; i++) f[i*CH +: CH] = CH'(4'b0001);
        run(f, 1'b0);
        // R9: one-to-one pairings overrun the fault map
        f = '0;
        for (int i = 0; i < L; i++) begin
            f[i*CH +: CH] = CH'(4'b0001);
            f[(L+i)*CH +: CH] = CH'(4'b0010);
        end
        run(f, 1'b0);
        // R10: stray start in the middle of a run
        f = '0;
        for (int i = 0; i < 2*L*CH; i++) f[i] = ($urandom % 4 == 0);
        run(f, 1'b1);
        // Random fault densities
        for (int r = 0; r < 40; r++) begin
            dens = 3 + (r % 4);
            f = '0;
            for (int i = 0; i < 2*L; i++) begin
                for (int c = 0; c < CH; c++) p[c] = ($urandom % dens == 0);
                f[i*CH +: CH] = p;
            end
            run(f, 1'b0);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule